// File: doc/BRIEF.md
# Constant-Peak-Current PFM Switch Timer

This block produces the gate-drive pulse for a pulse-skipping boost converter that runs in discontinuous conduction. Three digital flags come from analog comparators outside the block. The first enables the section. The second reports that the output is below its regulation target. The third reports that the switch-node voltage has fallen below the battery voltage. A digitised battery-voltage code sets the length of each pulse.

A pulse starts only when the converter is enabled, the output needs energy and the switch node sits below the battery. The on-time is a fixed volt-second constant divided by the battery code, so the inductor reaches the same peak current at any battery level. A free-running sequential divider computes this quotient, and the result is clamped between one cycle and a maximum given at a port.

After each pulse the block blanks the switch-node flag for a fixed number of cycles to mask ringing. It then waits until the flag shows that the inductor current has returned to zero. Only after that can another pulse start. If the output is already in regulation, no pulse starts. A pulse counter is provided so that a test can observe how many pulses have fired.

Top module: `pfm_switch_timer`

## Requirements
- R1: A pulse starts only when `en_i`, `below_reg_i` and `sw_low_i` are all high while the timer is idle. `gate_o` rises at the clock edge where the three flags are sampled high.
- R2: While `below_reg_i` is low, no pulse starts and `pulse_cnt_o` does not change, whatever the other inputs do.
- R3: The pulse width in clock cycles is VS_K / `batt_code_i` (integer quotient), clamped to the range 1 to M. M is `max_on_i`, except that a value of 0 is taken as 1. A code of 0 gives width M. A new code takes effect within 2*(K_W+1) cycles.
- R4: Once a pulse has started, changes on `below_reg_i` or `sw_low_i` do not shorten it.
- R5: If `en_i` is low at a clock edge, `gate_o` is low after that edge and the timer returns to idle. While `en_i` stays low, no pulse starts.
- R6: After each pulse, `gate_o` stays low for at least MIN_OFF+2 cycles. During the first MIN_OFF of those cycles `sw_low_i` is ignored. With continuous demand, the gap is exactly MIN_OFF+2 cycles.
- R7: Once blanking is over, the timer waits for `sw_low_i` to be high. When the flag rises, `gate_o` rises at the second clock edge that follows.
- R8: `pulse_cnt_o` increments by one at the edge on which each pulse starts, and wraps at its width.
- R9: After reset, `gate_o` is 0 and `pulse_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Section enable |
| below_reg_i | input | 1 | Output is below its regulation target |
| sw_low_i | input | 1 | Switch-node voltage is below battery voltage |
| batt_code_i | input | BATT_W | Digitised battery voltage |
| max_on_i | input | ON_W | Upper clamp on the pulse width, in cycles |
| gate_o | output | 1 | Switch gate drive |
| pulse_cnt_o | output | CNT_W | Count of pulses fired |

## Verification
On every cycle, assertions check the following:
- A rising gate was preceded by all three firing flags.
- A running pulse is not cut short while the section is enabled.
- Disabling the section forces the gate low and the timer back to idle.
- The blanking window keeps the timer out of idle.
- Each divider result satisfies the quotient bounds.
- The on-length stays inside its clamp.
- The counter steps once per pulse.

Only the directed scenarios can show the following:
- The exact pulse widths for different battery codes and clamp settings.
- The exact gap length.
- The two-edge response to a late switch-node flag.
- The absence of pulses when the output is in regulation.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_WAIT = 2'd2
  } pfm_state_e;
endpackage

// File: rtl/pfm_div.sv
// Free-running restoring divider: quo_o = VS_K / div_i, refreshed every K_W+1 cycles.
module pfm_div #(
  parameter int BATT_W = 8,
  parameter int K_W    = 12,
  parameter int VS_K   = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BATT_W-1:0] div_i,
  output logic [K_W-1:0]    quo_o
);
  localparam int CNT_W = $clog2(K_W + 1);

  logic [CNT_W-1:0]  step_q;
  logic [BATT_W-1:0] dvs_q;
  logic [BATT_W:0]   rem_q, rem_sh, rem_nx;
  logic [K_W-1:0]    sh_q, sh_nx, quo_q;
  logic              ge;

  always_comb begin
    rem_sh = {rem_q[BATT_W-1:0], sh_q[K_W-1]};
    ge     = rem_sh >= {1'b0, dvs_q};
    rem_nx = ge ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
    sh_nx  = {sh_q[K_W-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      sh_q   <= '0;
      quo_q  <= '1;
    end else if (step_q == '0) begin
      dvs_q  <= div_i;
      rem_q  <= '0;
      sh_q   <= K_W'(VS_K);
      step_q <= CNT_W'(K_W);
    end else begin
      rem_q  <= rem_nx;
      sh_q   <= sh_nx;
      step_q <= step_q - 1'b1;
      if (step_q == CNT_W'(1)) quo_q <= sh_nx;
    end
  end

  assign quo_o = quo_q;

  AST_DIV_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == CNT_W'(1) && dvs_q != '0) |=>
      (int'(quo_o) * int'($past(dvs_q)) <= VS_K) &&
      (VS_K < (int'(quo_o) + 1) * int'($past(dvs_q)))); // R3
endmodule

// File: rtl/pfm_on_time.sv
module pfm_on_time #(
  parameter int BATT_W = 8,
  parameter int K_W    = 12,
  parameter int VS_K   = 600,
  parameter int ON_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BATT_W-1:0] batt_code_i,
  input  logic [ON_W-1:0]   max_on_i,
  output logic [ON_W-1:0]   on_len_o
);
  logic [K_W-1:0]  quo;
  logic [K_W-1:0]  quo_min1;
  logic [ON_W-1:0] max_eff;

  pfm_div #(.BATT_W(BATT_W), .K_W(K_W), .VS_K(VS_K)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (batt_code_i),
    .quo_o  (quo)
  );

  always_comb begin
    max_eff  = (max_on_i == '0) ? ON_W'(1) : max_on_i;
    quo_min1 = (quo == '0) ? K_W'(1) : quo;
    if (quo_min1 > K_W'(max_eff)) on_len_o = max_eff;
    else                          on_len_o = ON_W'(quo_min1);
  end

  AST_ON_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_len_o != '0) && (max_on_i == '0 ? on_len_o == ON_W'(1) : on_len_o <= max_on_i)); // R3
endmodule

// File: rtl/pfm_off_guard.sv
// Blanking timer: counts MIN_OFF cycles after each pulse before the switch-node flag is trusted.
module pfm_off_guard #(
  parameter int MIN_OFF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int OFF_W = $clog2(MIN_OFF + 1);

  logic [OFF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= OFF_W'(MIN_OFF);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_BLANK_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o); // R6
endmodule

// File: rtl/pfm_fsm.sv
module pfm_fsm
  import pfm_pkg::*;
#(
  parameter int ON_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            below_reg_i,
  input  logic            sw_low_i,
  input  logic            guard_done_i,
  input  logic [ON_W-1:0] on_len_i,
  output logic            fire_o,
  output logic            pulse_end_o,
  output logic            gate_o
);
  pfm_state_e      state_q, state_d;
  logic [ON_W-1:0] on_cnt_q;
  logic            gate_q;

  assign fire_o      = (state_q == ST_IDLE) && en_i && below_reg_i && sw_low_i;
  assign pulse_end_o = (state_q == ST_ON) && en_i && (on_cnt_q == ON_W'(1));

  always_comb begin
    state_d = state_q;
    if (!en_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (fire_o) state_d = ST_ON;
        ST_ON:   if (pulse_end_o) state_d = ST_WAIT;
        ST_WAIT: if (guard_done_i && sw_low_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      on_cnt_q <= '0;
      gate_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= (state_d == ST_ON);
      if (fire_o)                  on_cnt_q <= on_len_i;
      else if (state_q == ST_ON)   on_cnt_q <= on_cnt_q - 1'b1;
    end
  end

  assign gate_o = gate_q;

  AST_FIRE_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(en_i && below_reg_i && sw_low_i)); // R1
  AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && on_cnt_q > ON_W'(1) && en_i) |=> gate_o); // R4
  AST_DISABLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!gate_o && state_q == ST_IDLE)); // R5
  AST_BLANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !guard_done_i && en_i) |=> state_q == ST_WAIT); // R6
endmodule

// File: rtl/pfm_switch_timer.sv
module pfm_switch_timer #(
  parameter int BATT_W  = 8,
  parameter int K_W     = 12,
  parameter int VS_K    = 600,
  parameter int ON_W    = 8,
  parameter int MIN_OFF = 3,
  parameter int CNT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              below_reg_i,
  input  logic              sw_low_i,
  input  logic [BATT_W-1:0] batt_code_i,
  input  logic [ON_W-1:0]   max_on_i,
  output logic              gate_o,
  output logic [CNT_W-1:0]  pulse_cnt_o
);
  logic [ON_W-1:0]  on_len;
  logic             fire, pulse_end, guard_done;
  logic [CNT_W-1:0] cnt_q;

  pfm_on_time #(.BATT_W(BATT_W), .K_W(K_W), .VS_K(VS_K), .ON_W(ON_W)) u_on_time (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .batt_code_i (batt_code_i),
    .max_on_i    (max_on_i),
    .on_len_o    (on_len)
  );

  pfm_off_guard #(.MIN_OFF(MIN_OFF)) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pulse_end),
    .done_o (guard_done)
  );

  pfm_fsm #(.ON_W(ON_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .below_reg_i  (below_reg_i),
    .sw_low_i     (sw_low_i),
    .guard_done_i (guard_done),
    .on_len_i     (on_len),
    .fire_o       (fire),
    .pulse_end_o  (pulse_end),
    .gate_o       (gate_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (fire) cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> pulse_cnt_o == $past(pulse_cnt_o) + 1'b1); // R8
  AST_CNT_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !below_reg_i |=> $stable(pulse_cnt_o)); // R2
endmodule

// File: tb/pfm_switch_timer_test.sv
`timescale 1ns/1ps
module pfm_switch_timer_test;
  localparam int MIN_OFF = 3;
  localparam int GAP     = MIN_OFF + 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, below_reg_i = 1'b0, sw_low_i = 1'b0;
  logic [7:0]  batt_code_i = 8'd100;
  logic [7:0]  max_on_i = 8'd255;
  logic        gate_o;
  logic [15:0] pulse_cnt_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pfm_switch_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .below_reg_i(below_reg_i),
    .sw_low_i(sw_low_i), .batt_code_i(batt_code_i), .max_on_i(max_on_i),
    .gate_o(gate_o), .pulse_cnt_o(pulse_cnt_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // gate is high at the current negedge; count high samples
  task automatic high_len(output int w);
    w = 0;
    while (gate_o && w < 400) begin w++; @(negedge clk); end
  endtask

  task automatic low_len(output int g);
    g = 0;
    while (!gate_o && g < 200) begin g++; @(negedge clk); end
  endtask

  task automatic settle(input logic [7:0] code, input logic [7:0] mx);
    below_reg_i = 1'b0; en_i = 1'b1; sw_low_i = 1'b1;
    batt_code_i = code; max_on_i = mx;
    step(60);
  endtask

  task automatic one_pulse(input logic [7:0] code, input logic [7:0] mx, input int exp, input string req);
    int w;
    settle(code, mx);
    below_reg_i = 1'b1;
    step(1);
    below_reg_i = 1'b0;
    check(gate_o == 1'b1, req, gate_o, 1);
    high_len(w);
    check(w == exp, req, w, exp);
  endtask

  task automatic t_reset;
    check(gate_o == 1'b0, "R9 gate", gate_o, 0);
    check(pulse_cnt_o == 16'd0, "R9 count", pulse_cnt_o, 0);
  endtask

  task automatic t_basic;
    int w, g;
    logic [15:0] c0;
    settle(8'd100, 8'd255);
    c0 = pulse_cnt_o;
    below_reg_i = 1'b1;
    step(1);
    check(gate_o == 1'b1, "R1 fire next edge", gate_o, 1);
    check(pulse_cnt_o == c0 + 16'd1, "R8 count step", pulse_cnt_o, c0 + 1);
    high_len(w);
    check(w == 6, "R3 width code 100", w, 6);
    low_len(g);
    check(g == GAP, "R6 gap continuous demand", g, GAP);
    high_len(w);
    check(w == 6, "R3 width second pulse", w, 6);
    below_reg_i = 1'b0;
    step(20);
    check(pulse_cnt_o == c0 + 16'd2, "R8 two pulses", pulse_cnt_o, c0 + 2);
  endtask

  task automatic t_regulated;
    logic [15:0] c0;
    int hi;
    settle(8'd100, 8'd255);
    c0 = pulse_cnt_o;
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      sw_low_i = i[0];
      step(1);
      if (gate_o) hi++;
    end
    sw_low_i = 1'b1;
    check(hi == 0, "R2 no pulse in regulation", hi, 0);
    check(pulse_cnt_o == c0, "R2 count unchanged", pulse_cnt_o, c0);
  endtask

  task automatic t_scaling;
    one_pulse(8'd25,  8'd255, 24,  "R3 code 25");
    one_pulse(8'd200, 8'd255, 3,   "R3 code 200");
    one_pulse(8'd250, 8'd255, 2,   "R3 code 250");
    one_pulse(8'd0,   8'd255, 255, "R3 code 0 max");
    one_pulse(8'd25,  8'd10,  10,  "R3 clamp max");
    one_pulse(8'd25,  8'd0,   1,   "R3 max zero as one");
  endtask

  task automatic t_hold;
    int w;
    settle(8'd100, 8'd255);
    below_reg_i = 1'b1;
    step(2);
    below_reg_i = 1'b0;
    sw_low_i = 1'b0;
    high_len(w);
    check(w == 5, "R4 rest of pulse kept", w, 5);
    sw_low_i = 1'b1;
  endtask

  task automatic t_disable;
    logic [15:0] c0;
    int hi;
    settle(8'd25, 8'd255);
    below_reg_i = 1'b1;
    step(3);
    check(gate_o == 1'b1, "R5 pulse running", gate_o, 1);
    en_i = 1'b0;
    step(1);
    check(gate_o == 1'b0, "R5 gate low next edge", gate_o, 0);
    c0 = pulse_cnt_o;
    hi = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (gate_o) hi++; end
    check(hi == 0, "R5 held low", hi, 0);
    check(pulse_cnt_o == c0, "R5 no fire while disabled", pulse_cnt_o, c0);
    en_i = 1'b1;
    step(1);
    check(gate_o == 1'b1, "R5 restarts from idle", gate_o, 1);
    below_reg_i = 1'b0;
    step(40);
  endtask

  task automatic t_blank;
    int w, g;
    settle(8'd200, 8'd255);
    below_reg_i = 1'b1;
    step(1);
    high_len(w);
    sw_low_i = 1'b0;
    step(1);
    sw_low_i = 1'b1;
    g = 1;
    low_len(w);
    g += w;
    check(g == GAP, "R6 flag ignored while blanking", g, GAP);
    below_reg_i = 1'b0;
    step(20);
  endtask

  task automatic t_zero_wait;
    int w, hi;
    settle(8'd100, 8'd255);
    below_reg_i = 1'b1;
    step(2);
    sw_low_i = 1'b0;
    high_len(w);
    hi = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (gate_o) hi++; end
    check(hi == 0, "R7 waits for zero current", hi, 0);
    sw_low_i = 1'b1;
    step(1);
    check(gate_o == 1'b0, "R7 first edge still low", gate_o, 0);
    step(1);
    check(gate_o == 1'b1, "R7 second edge high", gate_o, 1);
    below_reg_i = 1'b0;
    step(20);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_ni = 1'b1;
    step(2);
    t_reset();
    t_basic();
    t_regulated();
    t_scaling();
    t_hold();
    t_disable();
    t_blank();
    t_zero_wait();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule